// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serializes one low-speed USB packet onto the D+/D- pair. Its clock runs at ten times the bit rate. A start pulse launches a data packet. The block takes the bus in idle J and sends a SYNC byte it generates itself. It then sends the packet bytes fetched from a byte-read port, in address order. Every bit is NRZI-coded with bit stuffing. The packet ends with an end-of-packet sequence, after which the block lets go of the lines.

A second start input sends a handshake packet instead. The handshake packet carries SYNC plus one PID byte taken from an input port, and the buffer is not used. PID and CRC values are prepared outside the block.

At the end of a data packet, the block copies a pending device address into its active address output. A handshake never updates the address. When the bus is released, the block raises a one-cycle pulse so the owner can clear any edge or receive flag that its own transmission set.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, oe, dp, dm, busy and irq_clr are 0 and dev_addr is 0.
- R2: Once a start is accepted, the first visible change is one clock of J (dp=0, dm=1) with oe low. After that, oe goes high with J held for one bit time before the first SYNC bit.
- R3: Every bit occupies exactly BIT_CLKS clocks (default 10).
- R4: Bit slot 0 starts the SYNC byte 0x80. The buffer bytes at rd_addr 0, 1, 2 … follow it, and every byte goes out LSB first. byte_cnt includes the SYNC byte. Values below 2 are treated as 2 and values above 12 as 12. rd_data must be valid within 2 clocks of an rd_addr change.
- R5: NRZI: a 0 bit toggles the line and a 1 bit holds it. J is dp=0/dm=1 and K is dp=1/dm=0.
- R6: After six 1 bits in a row, one extra toggle is inserted, and this also happens after the final data bit. The run count starts at zero at SYNC.
- R7: hs_start sends a 2-byte packet, SYNC then hs_pid. If start and hs_start pulse together, the handshake is sent.
- R8: After the last slot, the lines show SE0 with oe high for 2 bit times. Next comes one clock of J with oe high, then one clock of J with oe low. After that dp and dm both return to 0.
- R9: On a data packet, dev_addr takes the value of pend_addr when SE0 begins. A handshake leaves dev_addr unchanged.
- R10: irq_clr pulses for exactly one clock, in the clock where oe first drops after the packet.
- R11: busy is high from the first prep J clock through the release clock. start and hs_start are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, ten times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: send a data packet |
| hs_start | input | 1 | Pulse: send a handshake packet |
| byte_cnt | input | 4 | Packet length including SYNC |
| hs_pid | input | 8 | PID byte for the handshake |
| rd_addr | output | 4 | Buffer read address |
| rd_data | input | 8 | Buffer read data |
| pend_addr | input | 7 | Device address waiting to be committed |
| dev_addr | output | 7 | Active device address |
| irq_clr | output | 1 | Pulse to clear self-induced receive flag |
| busy | output | 1 | Transmission in progress |
| oe | output | 1 | Line output enable |
| dp | output | 1 | D+ drive value |
| dm | output | 1 | D- drive value |

## Verification
The hardest cases to reach are stuffing that lands right before the end of packet and runs of ones that cross a byte boundary. Both change the slot count, and so they move every later edge of the end-of-packet sequence. The stimulus reaches them with directed buffers of 0xFF and a last byte 0xFC, whose six trailing ones force a stuffed bit just before SE0. Random packets draw each byte as 0xFF half the time. Start pulses arriving mid-packet, and both start inputs pulsed together, are driven on purpose.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_JLEAD, S_BITS, S_SE0, S_JEND, S_REL
  } tx_st_t;
endpackage

// File: rtl/usb_ls_tx_timer.sv
module usb_ls_tx_timer #(
  parameter int BIT_CLKS = 10,
  parameter int EOP_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic long_slot,
  output logic slot_end
);
  localparam int MAXC = BIT_CLKS * EOP_BITS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LIM_S = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] LIM_L = CW'(MAXC - 1);

  logic [CW-1:0] cnt;

  assign slot_end = en && (cnt == (long_slot ? LIM_L : LIM_S));

  always_ff @(posedge clk) begin
    if (rst || !en || slot_end) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R3: the slot counter never runs past the longest slot
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt <= LIM_L));
endmodule

// File: rtl/usb_ls_tx_ser.sv
module usb_ls_tx_ser #(
  parameter int MAX_BYTES = 12,
  parameter int STUFF_RUN = 6,
  parameter int AW = $clog2(MAX_BYTES),
  parameter int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] nrest,
  input  logic          step,
  input  logic [7:0]    nxt_byte,
  output logic          lvl,
  output logic          fin,
  output logic [AW-1:0] rd_addr
);
  localparam int RW = $clog2(STUFF_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_RUN);

  logic [7:0]    sh;
  logic [2:0]    bidx;
  logic [CW-1:0] left;
  logic [RW-1:0] ones;
  logic          done;

  assign fin = done && (ones != RUN_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; bidx <= '0; left <= '0; ones <= '0;
      done <= 1'b0; lvl <= 1'b1; rd_addr <= '0;
    end else if (load) begin
      sh <= 8'h80; bidx <= '0; left <= nrest; ones <= '0;
      done <= 1'b0; lvl <= 1'b1; rd_addr <= '0;
    end else if (step && !fin) begin
      if (ones == RUN_MAX) begin
        lvl  <= ~lvl;
        ones <= '0;
      end else begin
        if (!sh[0]) begin
          lvl  <= ~lvl;
          ones <= '0;
        end else begin
          ones <= ones + 1'b1;
        end
        if (bidx == 3'd7) begin
          bidx <= '0;
          if (left == '0) begin
            done <= 1'b1;
          end else begin
            sh      <= nxt_byte;
            left    <= left - 1'b1;
            rd_addr <= rd_addr + 1'b1;
          end
        end else begin
          sh   <= {1'b0, sh[7:1]};
          bidx <= bidx + 1'b1;
        end
      end
    end
  end

  // R6: a run of ones never exceeds the stuffing limit
  a_r6_run_bounded: assert property (@(posedge clk) disable iff (rst)
    ones <= RUN_MAX);
  // R6: a full run is always broken by a toggle on the next step
  a_r6_stuff_toggle: assert property (@(posedge clk) disable iff (rst)
    (step && !load && ones == RUN_MAX) |=> (lvl != $past(lvl)));
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int BIT_CLKS  = 10,
  parameter int EOP_BITS  = 2,
  parameter int MIN_BYTES = 2,
  parameter int MAX_BYTES = 12,
  parameter int ADDR_W    = 7,
  parameter int AW = $clog2(MAX_BYTES),
  parameter int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              hs_start,
  input  logic [CW-1:0]     byte_cnt,
  input  logic [7:0]        hs_pid,
  output logic [AW-1:0]     rd_addr,
  input  logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] pend_addr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              irq_clr,
  output logic              busy,
  output logic              oe,
  output logic              dp,
  output logic              dm
);
  localparam logic [CW-1:0] MINC = CW'(MIN_BYTES);
  localparam logic [CW-1:0] MAXC = CW'(MAX_BYTES);

  tx_st_t        st;
  logic          hs_q;
  logic [7:0]    pid_q;
  logic          go, slot_end, step, lvl, fin;
  logic [CW-1:0] cnt_c, nrest;

  assign go    = (st == S_IDLE) && !busy && (start || hs_start);
  assign cnt_c = (byte_cnt < MINC) ? MINC : (byte_cnt > MAXC) ? MAXC : byte_cnt;
  assign nrest = hs_start ? CW'(1) : cnt_c - 1'b1;
  assign step  = slot_end && (st == S_JLEAD || st == S_BITS);

  usb_ls_tx_timer #(.BIT_CLKS(BIT_CLKS), .EOP_BITS(EOP_BITS)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .en       (st == S_JLEAD || st == S_BITS || st == S_SE0),
    .long_slot(st == S_SE0),
    .slot_end (slot_end)
  );

  usb_ls_tx_ser #(.MAX_BYTES(MAX_BYTES), .AW(AW), .CW(CW)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .load    (go),
    .nrest   (nrest),
    .step    (step),
    .nxt_byte(hs_q ? pid_q : rd_data),
    .lvl     (lvl),
    .fin     (fin),
    .rd_addr (rd_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; hs_q <= 1'b0; pid_q <= '0; dev_addr <= '0;
    end else begin
      case (st)
        S_IDLE:  if (go) begin
                   st <= S_PREP; hs_q <= hs_start; pid_q <= hs_pid;
                 end
        S_PREP:  st <= S_JLEAD;
        S_JLEAD: if (slot_end) st <= S_BITS;
        S_BITS:  if (slot_end && fin) begin
                   st <= S_SE0;
                   if (!hs_q) dev_addr <= pend_addr;
                 end
        S_SE0:   if (slot_end) st <= S_JEND;
        S_JEND:  st <= S_REL;
        S_REL:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // registered line stage: outputs follow the state by one clock
  always_ff @(posedge clk) begin
    if (rst) begin
      oe <= 1'b0; dp <= 1'b0; dm <= 1'b0; busy <= 1'b0; irq_clr <= 1'b0;
    end else begin
      busy    <= (st != S_IDLE);
      irq_clr <= (st == S_REL);
      case (st)
        S_PREP:  begin oe <= 1'b0; dp <= 1'b0; dm <= 1'b1; end
        S_JLEAD: begin oe <= 1'b1; dp <= 1'b0; dm <= 1'b1; end
        S_BITS:  begin oe <= 1'b1; dp <= ~lvl; dm <= lvl;  end
        S_SE0:   begin oe <= 1'b1; dp <= 1'b0; dm <= 1'b0; end
        S_JEND:  begin oe <= 1'b1; dp <= 1'b0; dm <= 1'b1; end
        S_REL:   begin oe <= 1'b0; dp <= 1'b0; dm <= 1'b1; end
        default: begin oe <= 1'b0; dp <= 1'b0; dm <= 1'b0; end
      endcase
    end
  end

  // R5: both lines are never driven high together
  a_r5_no_se1: assert property (@(posedge clk) disable iff (rst)
    !(dp && dm));
  // R2: the output enable only rises onto an idle J
  a_r2_enable_on_j: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (dm && !dp));
  // R10: the flag-clear pulse coincides with the bus being let go
  a_r10_irq_release: assert property (@(posedge clk) disable iff (rst)
    irq_clr |-> (!oe && $past(oe)));
  // R9: the address moves only at the start of SE0 of a data packet
  a_r9_addr_data_only: assert property (@(posedge clk) disable iff (rst)
    (dev_addr != $past(dev_addr)) |-> ($past(st) == S_BITS && st == S_SE0 && !hs_q));
  // R11: a start while busy does not change the packet kind
  a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && (start || hs_start)) |=> $stable(hs_q));
endmodule

// File: tb/sim_usb_ls_tx.sv
module sim_usb_ls_tx;
  logic       clk = 1'b0;
  logic       rst;
  logic       start, hs_start;
  logic [3:0] byte_cnt;
  logic [7:0] hs_pid;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic [6:0] pend_addr, dev_addr;
  logic       irq_clr, busy, oe, dp, dm;

  logic [7:0] mem [0:15];
  logic       exp_lvl [0:255];
  int         nslots;
  int         n_chk = 0, n_bad = 0;
  logic [6:0] addr_model = '0;
  bit         fin_flag = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) rd_data <= mem[rd_addr];

  usb_ls_tx u0 (
    .clk(clk), .rst(rst), .start(start), .hs_start(hs_start),
    .byte_cnt(byte_cnt), .hs_pid(hs_pid), .rd_addr(rd_addr), .rd_data(rd_data),
    .pend_addr(pend_addr), .dev_addr(dev_addr), .irq_clr(irq_clr),
    .busy(busy), .oe(oe), .dp(dp), .dm(dm)
  );

  task automatic chk(input string req, input logic [6:0] got, input logic [6:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, expv, $time);
    end
  endtask

  // expected NRZI level of each slot, computed from the requirements
  task automatic build(input logic hs, input int n, input logic [7:0] pid);
    logic lv = 1'b1;
    int   ones = 0;
    nslots = 0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = (k == 0) ? 8'h80 : (hs ? pid : mem[k-1]);
      for (int i = 0; i < 8; i++) begin
        if (!b[i]) begin lv = ~lv; ones = 0; end
        else ones++;
        exp_lvl[nslots] = lv; nslots++;
        if (ones == 6) begin
          lv = ~lv; ones = 0;
          exp_lvl[nslots] = lv; nslots++;
        end
      end
    end
  endtask

  // packs {oe,dp,dm,busy,irq_clr}
  function automatic logic [6:0] pk(input logic o, input logic p, input logic m,
                                    input logic b, input logic q);
    return {2'b00, o, p, m, b, q};
  endfunction

  task automatic run_pkt(input logic hs, input logic both, input logic [3:0] cnt,
                         input logic [7:0] pid, input logic [6:0] pa, input int bump);
    int n, total;
    logic [6:0] e;
    string rq;
    n = hs ? 2 : ((cnt < 2) ? 2 : ((cnt > 12) ? 12 : int'(cnt)));
    build(hs, n, pid);
    @(negedge clk);
    byte_cnt = cnt; hs_pid = pid; pend_addr = pa;
    start = !hs || both; hs_start = hs;
    @(negedge clk);
    start = 0; hs_start = 0;
    @(negedge clk);
    chk("R2 prep", pk(oe, dp, dm, busy, irq_clr), pk(0, 0, 1, 1, 0));
    total = 10 + 10 * nslots + 23;
    for (int t = 0; t < total; t++) begin
      int u;
      if (t == 1) begin
        // rd_data must not be re-read wrongly if the bench changes pend_addr later
      end
      if (t == bump)     begin start = 1; hs_start = t[0]; byte_cnt = 4'd3; hs_pid = ~pid; end
      if (t == bump + 1) begin start = 0; hs_start = 0; end
      @(negedge clk);
      u = t - 10 - 10 * nslots;
      if (t < 10) begin
        e = pk(1, 0, 1, 1, 0); rq = "R2 lead J";
      end else if (u < 0) begin
        logic lv = exp_lvl[(t - 10) / 10];
        e = pk(1, ~lv, lv, 1, 0); rq = "R5/R6 bit slot";
      end else if (u < 20) begin
        e = pk(1, 0, 0, 1, 0); rq = "R8 SE0";
      end else if (u == 20) begin
        e = pk(1, 0, 1, 1, 0); rq = "R8 end J";
      end else if (u == 21) begin
        e = pk(0, 0, 1, 1, 1); rq = "R10 release";
      end else begin
        e = pk(0, 0, 0, 0, 0); rq = "R11 idle";
      end
      chk(rq, pk(oe, dp, dm, busy, irq_clr), e);
    end
    if (!hs) addr_model = pa;
    chk(hs ? "R9 handshake keeps addr" : "R9 data commits addr", dev_addr, addr_model);
    repeat (2) @(negedge clk);
    chk("R11 no relaunch", pk(oe, dp, dm, busy, irq_clr), pk(0, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    rst = 1; start = 0; hs_start = 0; byte_cnt = 0; hs_pid = 0; pend_addr = 0;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset outputs", pk(oe, dp, dm, busy, irq_clr), pk(0, 0, 0, 0, 0));
    chk("R1 reset addr", dev_addr, 7'd0);

    // R4 ordering with distinct bytes, R3 timing
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'h11 * i + 8'h03);
    run_pkt(0, 0, 4'd5, 8'h00, 7'h15, 40);
    // R6 stuffing across bytes and right before EOP
    mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'hFC;
    run_pkt(0, 0, 4'd4, 8'h00, 7'h2A, 55);
    // R4 clamps
    run_pkt(0, 0, 4'd1, 8'h00, 7'h33, 25);
    run_pkt(0, 0, 4'd15, 8'h00, 7'h44, 77);
    // R7 handshakes and R9 address kept
    run_pkt(1, 0, 4'd9, 8'hD2, 7'h55, 30);
    run_pkt(1, 1, 4'd9, 8'h5A, 7'h66, 31);
    // random packets
    for (int k = 0; k < 24; k++) begin
      for (int i = 0; i < 16; i++) mem[i] = ($urandom % 2) ? 8'hFF : 8'($urandom);
      run_pkt(($urandom % 4) == 0, ($urandom % 2) == 1, 4'($urandom), 8'($urandom),
              7'($urandom), 20 + int'($urandom % 60));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule